// File: doc/BRIEF.md
# Sequential Integer Quotient Unit

This block divides two 32-bit integers and returns only the quotient. Division can be unsigned or two's-complement signed. One quotient bit is produced per clock by a radix-2 restoring loop that works on operand magnitudes. The sign is applied after the last step, and signed results truncate toward zero. An operation starts with a one-cycle `start` pulse while the unit is idle. `busy` stays high while the loop runs. `done` pulses when the quotient is ready.

The unit never raises a fault. Two cases would otherwise be undefined:
- a zero divisor;
- the signed most-negative value divided by minus one.

In both cases the divisor is replaced by one, so the quotient equals the dividend.

A destination register index travels with each operation. The result is marked for write-back only when that index is nonzero, so that writes aimed at the hard-wired zero register are dropped.

Top module: `int_seq_divider`

## Requirements
- R1: With `is_signed` low and a nonzero divisor, `quotient` is the unsigned floor of dividend / divisor.
- R2: With `is_signed` high and no substitution case, `quotient` is the two's-complement quotient truncated toward zero, so -7 / 2 gives -3 and 7 / -2 gives -3.
- R3: A divisor of 0 yields `quotient` equal to the dividend, in both signed and unsigned mode.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF yields 0x80000000. In unsigned mode the same operands give 0.
- R5: A `start` sampled while idle is accepted. `busy` is high from the following cycle, and `done` rises exactly 32 clock edges after the accepting edge, at which point `busy` falls.
- R6: A `start` while `busy` is high is ignored: no extra `done`, and the running result is unchanged.
- R7: `done` is high for exactly one cycle per operation. `quotient` keeps its value until the next operation completes.
- R8: `wr_en` is high in the `done` cycle only if the index captured at `start` is nonzero. `wr_idx` then carries that index.
- R9: While `rst_n` is low, `busy`, `done` and `wr_en` are 0 and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| is_signed | input | 1 | 1: two's-complement division, 0: unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| dst_idx | input | 5 | Destination register index carried with the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result, held until the next completion |
| wr_en | output | 1 | Write-back request, only for a nonzero index |
| wr_idx | output | 5 | Index for the write-back |

## Verification
The embedded assertions check several properties on every cycle:
- `done` is a single-cycle pulse;
- `quotient` only moves on a completion;
- `wr_en` never appears without `done` or with index zero;
- `busy` only rises after a `start`;
- the stored divisor is never zero while running;
- the partial remainder always stays below the divisor.

The numerical correctness of the quotient under each mode and corner case needs the bench's scoreboard. The same is true of the exact 32-cycle latency and of a `start` during `busy` being ignored. The scoreboard compares each completion against an independent model across zero, ±1, the most-negative value, all-ones and random operands.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_res
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic zero_dvs, ovf_case, subst, a_neg, b_neg;

  always_comb begin
    zero_dvs = (divisor == '0);
    ovf_case = is_signed && (dividend == MOST_NEG) && (divisor == '1);
    subst    = zero_dvs || ovf_case;
    a_neg    = is_signed && dividend[W-1];
    b_neg    = is_signed && divisor[W-1] && !subst;
    dvd_mag  = a_neg ? (-dividend) : dividend;
    if (subst) dvs_mag = ONE;
    else       dvs_mag = b_neg ? (-divisor) : divisor;
    neg_res  = a_neg ^ b_neg;
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] q_step
);
  localparam int CW = $clog2(W + 1);

  div_state_e  st_r, st_n;
  logic [W-1:0] rem_r, rem_n, q_r, q_n, dvs_r, dvs_n;
  logic [CW-1:0] cnt_r, cnt_n;

  logic [W:0]   shifted, trial;
  logic         fits;
  logic [W-1:0] rem_step;

  always_comb begin
    shifted  = {rem_r, q_r[W-1]};
    trial    = shifted - {1'b0, dvs_r};
    fits     = !trial[W];
    rem_step = fits ? trial[W-1:0] : shifted[W-1:0];
    q_step   = {q_r[W-2:0], fits};
  end

  assign busy   = (st_r == ST_RUN);
  assign finish = busy && (cnt_r == CW'(1));

  always_comb begin
    st_n  = st_r;
    rem_n = rem_r;
    q_n   = q_r;
    dvs_n = dvs_r;
    cnt_n = cnt_r;
    if (st_r == ST_IDLE) begin
      if (load) begin
        st_n  = ST_RUN;
        rem_n = '0;
        q_n   = dvd_mag;
        dvs_n = dvs_mag;
        cnt_n = CW'(W);
      end
    end else begin
      rem_n = rem_step;
      q_n   = q_step;
      cnt_n = cnt_r - CW'(1);
      if (cnt_r == CW'(1)) st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= ST_IDLE;
      rem_r <= '0;
      q_r   <= '0;
      dvs_r <= '0;
      cnt_r <= '0;
    end else begin
      st_r  <= st_n;
      rem_r <= rem_n;
      q_r   <= q_n;
      dvs_r <= dvs_n;
      cnt_r <= cnt_n;
    end
  end

  // R3 / R4: substitution leaves a nonzero divisor in the loop
  assert_dvs_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dvs_r != '0));
  // R1: restoring invariant, the partial remainder stays below the divisor
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_r < dvs_r));
endmodule

// File: rtl/idiv_sign.sv
module idiv_sign #(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic         neg,
  output logic [W-1:0] q_out
);
  always_comb q_out = neg ? (-q_mag) : q_mag;
endmodule

// File: rtl/int_seq_divider.sv
module int_seq_divider #(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [W-1:0]     dividend,
  input  logic [W-1:0]     divisor,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     quotient,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  logic [W-1:0] dvd_mag, dvs_mag, q_step, q_signed;
  logic         neg_res, finish, accept;

  logic             neg_r, neg_n;
  logic [IDX_W-1:0] idx_r, idx_n, wr_idx_n;
  logic             done_n, wr_en_n;
  logic [W-1:0]     quot_n;

  idiv_prep #(.W(W)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .is_signed(is_signed),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .neg_res  (neg_res)
  );

  idiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .dvd_mag(dvd_mag),
    .dvs_mag(dvs_mag),
    .busy   (busy),
    .finish (finish),
    .q_step (q_step)
  );

  idiv_sign #(.W(W)) u_sign (
    .q_mag(q_step),
    .neg  (neg_r),
    .q_out(q_signed)
  );

  assign accept = start && !busy;

  always_comb begin
    neg_n    = accept ? neg_res : neg_r;
    idx_n    = accept ? dst_idx : idx_r;
    done_n   = finish;
    wr_en_n  = finish && (idx_r != '0);
    quot_n   = finish ? q_signed : quotient;
    wr_idx_n = finish ? idx_r : wr_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_r    <= 1'b0;
      idx_r    <= '0;
      done     <= 1'b0;
      wr_en    <= 1'b0;
      quotient <= '0;
      wr_idx   <= '0;
    end else begin
      neg_r    <= neg_n;
      idx_r    <= idx_n;
      done     <= done_n;
      wr_en    <= wr_en_n;
      quotient <= quot_n;
      wr_idx   <= wr_idx_n;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: the result only changes on a completion
  assert_quot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient));
  // R8: write-back only with done and a nonzero index
  assert_wr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && (wr_idx != '0)));
  // R5: busy rises only after an accepted start
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5: busy falls exactly when done appears
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/tb_int_seq_divider.sv
module tb_int_seq_divider;
  localparam int LAT = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, is_signed;
  logic [31:0] dividend, divisor;
  logic [4:0]  dst_idx;
  logic        busy, done, wr_en;
  logic [31:0] quotient;
  logic [4:0]  wr_idx;

  always #5 clk = ~clk;

  int_seq_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .dst_idx(dst_idx),
    .busy(busy), .done(done), .quotient(quotient),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  typedef struct {
    logic [31:0] q;
    logic [4:0]  idx;
    int          t0;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic        prev_done = 1'b0;
  logic        have_last = 1'b0;
  logic [31:0] last_q;
  int          hold_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input bit s);
    if (b == 32'd0) return a;
    if (s) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
      return 32'($signed(a) / $signed(b));
    end
    return a / b;
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                   input bit s);
    if (b == 32'd0) return "R3";
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R4";
    if (s) return "R2";
    return "R1";
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s,
                       input logic [4:0] idx);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    dividend  = a;
    divisor   = b;
    is_signed = s;
    dst_idx   = idx;
    start     = 1'b1;
    e.q   = model(a, b, s);
    e.idx = idx;
    e.t0  = cyc;
    e.tag = tag_of(a, b, s);
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // R6: a start while busy must not be taken
  task automatic poke_busy(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    if (busy) begin
      dividend  = a;
      divisor   = b;
      is_signed = 1'b1;
      dst_idx   = 5'd9;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (prev_done && done) chk(1'b0, "R7 done longer than one cycle", 32'(done), 32'd0);
      if (done) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R6 unexpected done", quotient, 32'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(quotient === e.q, e.tag, quotient, e.q);
          chk(cyc == e.t0 + 1 + LAT, "R5 latency", 32'(cyc - e.t0), 32'(1 + LAT));
          chk(wr_en === (e.idx != 5'd0), "R8 wr_en", 32'(wr_en), 32'(e.idx != 5'd0));
          if (e.idx != 5'd0) chk(wr_idx === e.idx, "R8 wr_idx", 32'(wr_idx), 32'(e.idx));
          chk(!busy, "R5 busy low at done", 32'(busy), 32'd0);
        end
        if (have_last) chk(hold_bad == 0, "R7 hold", 32'(hold_bad), 32'd0);
        hold_bad  = 0;
        last_q    = quotient;
        have_last = 1'b1;
      end else if (have_last && quotient !== last_q) begin
        hold_bad++;
      end
      prev_done = done;
    end
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0;
    dividend = '0; divisor = '0; dst_idx = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 busy", 32'(busy), 32'd0);
    chk(done === 1'b0, "R9 done", 32'(done), 32'd0);
    chk(wr_en === 1'b0, "R9 wr_en", 32'(wr_en), 32'd0);
    chk(quotient === 32'd0, "R9 quotient", quotient, 32'd0);
    rst_n = 1'b1;

    // busy rises the cycle after start (R5)
    issue(32'd100, 32'd7, 1'b0, 5'd3);
    chk(busy === 1'b1, "R5 busy after start", 32'(busy), 32'd1);
    poke_busy(32'd1, 32'd1);            // R6
    poke_busy(32'hFFFF_FFFF, 32'd0);    // R6
    // corners: R3, R4, R1, R2
    issue(32'd0, 32'd0, 1'b0, 5'd1);
    issue(32'd5, 32'd0, 1'b0, 5'd0);
    issue(32'hFFFF_FFFB, 32'd0, 1'b1, 5'd2);
    issue(32'h1234_5678, 32'd0, 1'b1, 5'd31);
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 5'd4);
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'd5);
    issue(32'hFFFF_FFFF, 32'd1, 1'b0, 5'd6);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd7);
    issue(32'hFFFF_FFF9, 32'd2, 1'b1, 5'd8);
    issue(32'd7, 32'hFFFF_FFFE, 1'b1, 5'd0);
    issue(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 5'd10);
    issue(32'h8000_0000, 32'd1, 1'b1, 5'd11);
    issue(32'h8000_0000, 32'd2, 1'b1, 5'd12);
    issue(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd13);
    issue(32'd3, 32'd10, 1'b0, 5'd14);
    poke_busy(32'd50, 32'd5);           // R6
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? ($urandom & 32'h0000_00FF) : $urandom;
      issue(a, b, 1'(i % 2), 5'($urandom));
    end
    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R6 leftover", 32'(sbq.size()), 32'd0);
    chk(hold_bad == 0, "R7 final hold", 32'(hold_bad), 32'd0);
    finish_run();
  end
endmodule